// File: doc/BRIEF.md
# Rotational Sector and Word Position Tracker

This block follows the rotation of a removable disk platter from two pulse inputs: a sector-mark pulse that occurs eight times per revolution, and an index pulse that occurs once per revolution. It reports which sector is currently passing under the heads. It also follows a fixed layout inside each sector and reports which part of that layout is under the head: the leading run of zero bits, the sync word, one of the data words, or the trailing pad.

During the data part of a sector, the block presents the index of the current word and a one-cycle strobe at the start of each word. It also presents a word address for a backing memory that stands in for the platter. The address is built from the cylinder, the head-select level, the sector number and the word index. All intervals are counted in system clocks from parameters that describe the clock frequency and the layout times.

The heads-loaded level gates all word activity. When the heads are unloaded, the layout tracker idles. Sector tracking continues, because the platter keeps turning.

Top module: `rot_position_tracker`

## Requirements
- R1: During and after a synchronous active-low reset, the outputs hold these values: sector 0, sector_valid 0, stage 0 (idle), word_idx 0, word_strobe 0.
- R2: A rising edge of idx_mark sets the sector to 0 and sector_valid to 1 in the next cycle. The index pulse is expected after the falling edge of the mark that opens sector 0. If the index edge coincides with a mark falling edge, the index wins and layout timing still starts on that edge.
- R3: After synchronisation, each falling edge of sec_mark advances the sector by one, wrapping from 7 to 0. Before synchronisation the sector stays at 0.
- R4: Layout timing starts on a sec_mark falling edge while heads_loaded is high and the sector is valid (or an index edge coincides). The stage then reads 1 (zero run) for ZERO_US*CLK_MHZ cycles and 2 (sync) for one word time. A new falling edge restarts this sequence from any stage.
- R5: In stage 3 (data), word_idx runs 0 to NUM_WORDS-1. Each word lasts WORD_NS*CLK_MHZ/1000 cycles. word_strobe is high only in the first cycle of each word.
- R6: After the last data word, the stage reads 4 (pad) with word_idx 0 until the next mark falling edge.
- R7: word_addr is {cyl, head_sel, sector, word_idx}, with the cylinder in the top bits and word_idx in the low bits.
- R8: While heads_loaded is low, the stage reads 0, word_idx reads 0 and word_strobe reads 0 from the next cycle onward. Timing resumes only at a later mark falling edge seen with heads_loaded high. Sector counting is unaffected.
- R9: sector_coarse equals sector divided by 2, and sector_odd equals bit 0 of sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_mark | input | 1 | Sector-mark pulse, synchronous to clk |
| idx_mark | input | 1 | Index pulse, synchronous to clk |
| head_sel | input | 1 | Top/bottom head select level |
| heads_loaded | input | 1 | High while heads are loaded |
| cyl | input | CYL_W (8) | Current cylinder number |
| sector | output | 3 | Current sector number |
| sector_valid | output | 1 | Sector number synchronised to the index |
| sector_coarse | output | 2 | Sector number divided by two |
| sector_odd | output | 1 | Sector is odd (masked in the four-sector view) |
| stage | output | 3 | 0 idle, 1 zero run, 2 sync, 3 data, 4 pad |
| word_idx | output | WORD_W (9) | Current data word index |
| word_strobe | output | 1 | First cycle of each data word |
| word_addr | output | ADDR_W (21) | Composed memory address of current word |

## Verification
The index rising edge and a sector-mark falling edge can land in the same clock. The sector counter must then choose the reset to 0 over the increment, and the layout timer must start even though the sector was not yet valid before that edge. The bench drives the index pulse so that it rises on exactly the cycle the mark falls, with a cycle-accurate reference model following alongside. The sector, valid flag, stage and word outputs are compared with the model on every following clock. A mark that arrives in the middle of the data stage also restarts the layout, and the same model comparison covers that case.

// File: rtl/rot_pkg.sv
// Shared types for the rotational position tracker.
package rot_pkg;
    // Stage of the per-sector layout; codes are visible on the stage port.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ZERO = 3'd1,
        ST_SYNC = 3'd2,
        ST_DATA = 3'd3,
        ST_PAD  = 3'd4
    } stage_t;
endpackage

// File: rtl/rot_sector_count.sv
// Sector identity from mark and index pulses.
// Detects the sector-mark falling edge and the index rising edge, and keeps
// the sector number, which is valid once the first index edge has been seen.
// Assumes both pulses are already synchronous to clk.
module rot_sector_count #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_mark,
    input  logic              idx_mark,
    output logic              mark_fall,
    output logic              idx_edge,
    output logic [SECT_W-1:0] sector,
    output logic              valid
);
    logic sm_q, im_q;

    // Previous pulse levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sm_q <= 1'b0;
            im_q <= 1'b0;
        end else begin
            sm_q <= sec_mark;
            im_q <= idx_mark;
        end
    end

    assign mark_fall = sm_q & ~sec_mark;
    assign idx_edge  = idx_mark & ~im_q;

    // Sector number: index forces 0, each mark fall advances once synced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector <= '0;
            valid  <= 1'b0;
        end else if (idx_edge) begin
            sector <= '0;
            valid  <= 1'b1;
        end else if (mark_fall && valid) begin
            sector <= (sector == SECT_W'(NUM_SECT - 1)) ? '0 : sector + 1'b1;
        end
    end

    a_r2_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        idx_edge |=> (sector == '0) && valid);

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_fall && valid && !idx_edge) |=>
            (int'(sector) == (int'($past(sector)) + 1) % NUM_SECT));

    a_r3_hold_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> sector == '0);
endmodule

// File: rtl/rot_stage_timer.sv
// Per-sector layout timer.
// From a start pulse it walks zero run, sync word, data words and pad,
// counting clocks, and gives the word index and a word-start strobe.
// Assumes start is a single-cycle pulse; loaded low overrides everything.
module rot_stage_timer
    import rot_pkg::*;
#(
    parameter int ZERO_CYC  = 12500,
    parameter int WORD_CYC  = 1400,
    parameter int NUM_WORDS = 321,
    localparam int WORD_W  = $clog2(NUM_WORDS),
    localparam int CNT_MAX = (ZERO_CYC > WORD_CYC) ? ZERO_CYC : WORD_CYC,
    localparam int CNT_W   = $clog2(CNT_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loaded,
    output stage_t            stage,
    output logic [WORD_W-1:0] word,
    output logic              strobe
);
    logic [CNT_W-1:0] cnt;
    logic             zero_end, word_end, last_word;

    assign zero_end  = (cnt == CNT_W'(ZERO_CYC - 1));
    assign word_end  = (cnt == CNT_W'(WORD_CYC - 1));
    assign last_word = (word == WORD_W'(NUM_WORDS - 1));

    // Layout state machine with shared phase counter and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage  <= ST_IDLE;
            cnt    <= '0;
            word   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (!loaded) begin
                stage <= ST_IDLE;
                cnt   <= '0;
                word  <= '0;
            end else if (start) begin
                stage <= ST_ZERO;
                cnt   <= '0;
                word  <= '0;
            end else begin
                case (stage)
                    ST_ZERO: begin
                        if (zero_end) begin
                            stage <= ST_SYNC;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_SYNC: begin
                        if (word_end) begin
                            stage  <= ST_DATA;
                            cnt    <= '0;
                            word   <= '0;
                            strobe <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (word_end) begin
                            cnt <= '0;
                            if (last_word) begin
                                stage <= ST_PAD;
                                word  <= '0;
                            end else begin
                                word   <= word + 1'b1;
                                strobe <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    a_r8_unload_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |=> (stage == ST_IDLE) && !strobe && (word == '0));

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && loaded) |=> (stage == ST_ZERO) && (word == '0));

    a_r5_strobe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> stage == ST_DATA);

    a_r5_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word) < NUM_WORDS);

    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(stage) == ST_DATA) |-> word == $past(word) + 1'b1);

    a_r6_pad_word: assert property (@(posedge clk) disable iff (!rst_n)
        stage == ST_PAD |-> word == '0);
endmodule

// File: rtl/rot_position_tracker.sv
// Rotational sector and word position tracker (top).
// Combines sector identity with the per-sector layout timer and composes
// the memory address of the word under the head. Interval lengths come
// from the clock frequency in MHz and the layout times.
module rot_position_tracker
    import rot_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int ZERO_US   = 250,
    parameter int WORD_NS   = 28000,
    parameter int NUM_WORDS = 321,
    parameter int NUM_SECT  = 8,
    parameter int CYL_W     = 8,
    localparam int ZERO_CYC = ZERO_US * CLK_MHZ,
    localparam int WORD_CYC = (WORD_NS * CLK_MHZ) / 1000,
    localparam int SECT_W   = $clog2(NUM_SECT),
    localparam int WORD_W   = $clog2(NUM_WORDS),
    localparam int ADDR_W   = CYL_W + 1 + SECT_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_mark,
    input  logic              idx_mark,
    input  logic              head_sel,
    input  logic              heads_loaded,
    input  logic [CYL_W-1:0]  cyl,
    output logic [SECT_W-1:0] sector,
    output logic              sector_valid,
    output logic [SECT_W-2:0] sector_coarse,
    output logic              sector_odd,
    output logic [2:0]        stage,
    output logic [WORD_W-1:0] word_idx,
    output logic              word_strobe,
    output logic [ADDR_W-1:0] word_addr
);
    logic   mark_fall, idx_edge, start;
    stage_t stage_q;

    rot_sector_count #(.NUM_SECT(NUM_SECT)) u_sect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_mark  (sec_mark),
        .idx_mark  (idx_mark),
        .mark_fall (mark_fall),
        .idx_edge  (idx_edge),
        .sector    (sector),
        .valid     (sector_valid)
    );

    // Layout starts on a mark fall once synced, or with a coincident index.
    assign start = mark_fall & (sector_valid | idx_edge);

    rot_stage_timer #(
        .ZERO_CYC  (ZERO_CYC),
        .WORD_CYC  (WORD_CYC),
        .NUM_WORDS (NUM_WORDS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .loaded (heads_loaded),
        .stage  (stage_q),
        .word   (word_idx),
        .strobe (word_strobe)
    );

    // Output composition: stage code, coarse sector view, word address.
    assign stage         = stage_q;
    assign sector_coarse = sector[SECT_W-1:1];
    assign sector_odd    = sector[0];
    assign word_addr     = {cyl, head_sel, sector, word_idx};

    a_r2_timed_only_synced: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q != ST_IDLE |-> sector_valid);

    a_r4_zero_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_fall && heads_loaded && idx_edge) |=> stage_q == ST_ZERO);
endmodule

// File: tb/rot_position_tracker_test.sv
// Bench: behavioural per-cycle reference model compared on every clock.
// Timing parameters are scaled down (CLK_MHZ=1, 10 words) to keep runs short.
module rot_position_tracker_test;
    localparam int Z = 250;
    localparam int W = 28;
    localparam int N = 10;

    logic       clk = 1'b0;
    logic       rst_n, sec_mark, idx_mark, head_sel, heads_loaded;
    logic [7:0] cyl;
    logic [2:0] sector;
    logic       sector_valid;
    logic [1:0] sector_coarse;
    logic       sector_odd;
    logic [2:0] stage;
    logic [3:0] word_idx;
    logic       word_strobe;
    logic [15:0] word_addr;

    rot_position_tracker #(
        .CLK_MHZ(1), .ZERO_US(250), .WORD_NS(28000), .NUM_WORDS(N),
        .NUM_SECT(8), .CYL_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sec_mark(sec_mark), .idx_mark(idx_mark),
        .head_sel(head_sel), .heads_loaded(heads_loaded), .cyl(cyl),
        .sector(sector), .sector_valid(sector_valid),
        .sector_coarse(sector_coarse), .sector_odd(sector_odd),
        .stage(stage), .word_idx(word_idx), .word_strobe(word_strobe),
        .word_addr(word_addr)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int m_smq, m_imq, m_sec, m_valid, m_stage, m_cnt, m_word, m_strobe;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_smq = 0; m_imq = 0; m_sec = 0; m_valid = 0;
            m_stage = 0; m_cnt = 0; m_word = 0; m_strobe = 0;
        end else begin
            int fall, idx, start;
            fall  = (m_smq == 1 && sec_mark == 0);
            idx   = (idx_mark == 1 && m_imq == 0);
            start = fall && (m_valid || idx);
            m_strobe = 0;
            if (!heads_loaded) begin
                m_stage = 0; m_cnt = 0; m_word = 0;
            end else if (start) begin
                m_stage = 1; m_cnt = 0; m_word = 0;
            end else if (m_stage == 1) begin
                if (m_cnt == Z - 1) begin m_stage = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_stage == 2) begin
                if (m_cnt == W - 1) begin
                    m_stage = 3; m_cnt = 0; m_word = 0; m_strobe = 1;
                end else m_cnt++;
            end else if (m_stage == 3) begin
                if (m_cnt == W - 1) begin
                    m_cnt = 0;
                    if (m_word == N - 1) begin m_stage = 4; m_word = 0; end
                    else begin m_word++; m_strobe = 1; end
                end else m_cnt++;
            end
            if (idx) begin m_sec = 0; m_valid = 1; end
            else if (fall && m_valid) m_sec = (m_sec + 1) % 8;
            m_smq = sec_mark;
            m_imq = idx_mark;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (run && rst_n && !done) begin
            chk("R3 sector", sector, m_sec);
            chk("R2 sector_valid", sector_valid, m_valid);
            chk("R4/R6/R8 stage", stage, m_stage);
            chk("R5 word_idx", word_idx, m_word);
            chk("R5 word_strobe", word_strobe, m_strobe);
            chk("R7 word_addr", word_addr,
                (int'(cyl) << 8) | (int'(head_sel) << 7) | (m_sec << 4) | m_word);
            chk("R9 sector_coarse", sector_coarse, m_sec / 2);
            chk("R9 sector_odd", sector_odd, m_sec % 2);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // One mark period: mark high for hi cycles, optional index idx_at after fall.
    task automatic sector_mark(input int hi, input int period, input int idx_at);
        for (int c = 0; c < period; c++) begin
            sec_mark = (c < hi);
            idx_mark = (idx_at >= 0 && c >= hi + idx_at && c < hi + idx_at + 8);
            cyc(1);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sec_mark = 1'b0; idx_mark = 1'b0;
        head_sel = 1'b0; heads_loaded = 1'b0; cyl = 8'd37;
        cyc(4);
        // R1: reset state
        chk("R1 reset sector", sector, 0);
        chk("R1 reset valid", sector_valid, 0);
        chk("R1 reset stage", stage, 0);
        chk("R1 reset word", word_idx, 0);
        chk("R1 reset strobe", word_strobe, 0);
        rst_n = 1'b1;
        run = 1'b1;
        heads_loaded = 1'b1;
        cyc(5);
        // R3: unsynced marks keep sector 0 and no timing
        sector_mark(60, 700, -1);
        sector_mark(60, 700, -1);
        // R2: index after the mark that opens sector 0
        sector_mark(60, 700, 20);
        // R4 R5 R6 R7: a full revolution with head and cylinder changes
        for (int i = 0; i < 9; i++) begin
            if (i == 2) head_sel = 1'b1;
            if (i == 4) cyl = 8'd202;
            sector_mark(60, 700, (i == 7) ? 20 : -1);
        end
        // R8: heads unloaded in the middle of the data stage
        sector_mark(60, 400, -1);
        heads_loaded = 1'b0;
        cyc(100);
        heads_loaded = 1'b1;
        cyc(200);
        // R4: marks arriving during the data stage restart the layout
        sector_mark(60, 450, -1);
        sector_mark(60, 450, -1);
        // R2: index edge in the same cycle as the mark fall
        sector_mark(60, 700, 0);
        for (int i = 0; i < 8; i++) begin
            head_sel = i[0];
            sector_mark(60, 700, (i == 7) ? 20 : -1);
        end
        cyc(10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule